// File: doc/BRIEF.md
# Serial Result Shift-Out Port

This block sits on the converter side of a two-wire read interface. When the conversion engine completes a sample, it offers the result as one beat on a valid/ready stream. The port turns that result into a fixed-length frame: a run of zero pad bits comes first, then the result, most significant bit first, in plain unsigned binary. A remote reader drives an asynchronous serial clock. Each falling edge of that clock moves the data line on by one bit. After the last falling edge of the frame, the output enable drops so the pad can float the line. While no transfer runs, the serial clock rests low.

The serial clock is resynchronized into the system clock domain through a chain of flip-flops, and its falling edges are detected there. The stream input applies no back-pressure. `res_ready` is high in every cycle from the first clock edge after reset. An accepted beat always wins: it restarts the frame from bit 0, even when a frame is half sent. The producer may therefore hold `res_valid` for a single cycle.

With the defaults (12 result bits, 4 pad bits), a frame is 16 bits long. The system clock must run well above the serial clock. Each serial half-period needs at least SYNC_STAGES + 2 system clock cycles. At a 10 MHz serial clock, this means a system clock of about 80 MHz or more.

Top module: `sdo_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sdata_oe` is 0 and `sdata` is 0.
- R2: In the cycle after a beat is accepted (`res_valid` and `res_ready` both high), `sdata_oe` is 1 and `sdata` shows frame bit 0, which is a pad zero.
- R3: Frame bit i (0-based) is 0 for i < PAD_W. For PAD_W <= i < PAD_W+RES_W, it equals `res_data[RES_W-1-(i-PAD_W)]` of the accepted beat, sent as unsigned binary and unmodified.
- R4: Each falling edge of `sclk`, once resynchronized, advances `sdata` by exactly one frame bit. Rising edges of `sclk` do not change `sdata` or `sdata_oe`.
- R5: The falling edge numbered PAD_W+RES_W after a load drops `sdata_oe` to 0. Later `sclk` edges leave it at 0.
- R6: `sclk` edges that arrive when no beat has been accepted since reset or since the last release leave `sdata_oe` at 0.
- R7: A beat accepted in the middle of a frame discards the old frame. The next frame starts at bit 0 with the new result.
- R8: `res_ready` is 1 in every cycle after the first clock edge following reset.
- R9: `sdata` is 0 whenever `sdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the reader, asynchronous to `clk`, idles low |
| res_valid | input | 1 | Result beat offered |
| res_ready | output | 1 | Beat accepted when high together with `res_valid` |
| res_data | input | RES_W | Conversion result, unsigned binary |
| sdata | output | 1 | Serial data bit, 0 while released |
| sdata_oe | output | 1 | Drive enable for the tri-state data pad |

## Verification
The bench builds the port with RES_W=6, PAD_W=2 and SYNC_STAGES=2. This gives an 8-bit frame and 64 possible results. That size allows every result value to be shifted out in full. Every bit position is compared against the arithmetic expectation, and each bit is also held across a rising edge. The short frame also makes it cheap to test the rest of the behaviour: a reload in the middle of a frame, release at the final falling edge, and serial clock edges after release and before any load.

// File: rtl/sdo_pkg.sv
package sdo_pkg;

  typedef enum logic {
    SDO_IDLE  = 1'b0,
    SDO_SHIFT = 1'b1
  } sdo_state_e;

endpackage

// File: rtl/sdo_edge_sync.sv
module sdo_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // resynchronizer chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
  import sdo_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] load_data,
  input  logic             step,
  output logic             bit_out,
  output logic             active
);

  localparam int unsigned FRAME_W = RES_W + PAD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  sdo_state_e         state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SDO_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      state_q <= SDO_SHIFT;
      frame_q <= {{PAD_W{1'b0}}, load_data};
      idx_q   <= '0;
    end else if (step && state_q == SDO_SHIFT) begin
      if (idx_q == LAST_IDX) begin
        state_q <= SDO_IDLE;
        idx_q   <= '0;
      end else begin
        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign active  = (state_q == SDO_SHIFT);
  assign bit_out = active & frame_q[FRAME_W-1];

endmodule

// File: rtl/sdo_port.sv
module sdo_port #(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned PAD_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic             sdata,
  output logic             sdata_oe
);

  logic ready_q;
  logic sclk_fall;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign res_ready = ready_q;
  assign accept    = res_valid & ready_q;

  sdo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sclk),
    .fall     (sclk_fall)
  );

  sdo_shifter #(.RES_W(RES_W), .PAD_W(PAD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (res_data),
    .step      (sclk_fall),
    .bit_out   (sdata),
    .active    (sdata_oe)
  );

endmodule

// File: rtl/sdo_port_chk.sv
module sdo_port_chk #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned PAD_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic res_ready,
  input logic sdata,
  input logic sdata_oe,
  input logic fall
);

  localparam int unsigned FRAME_W = RES_W + PAD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic             take;
  logic [CNT_W-1:0] seen_q;

  assign take = res_valid & res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_q <= '0;
    else if (take)             seen_q <= '0;
    else if (fall && sdata_oe) seen_q <= seen_q + 1'b1;
  end

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sdata_oe && !sdata));

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && !fall && !take) |=> (sdata_oe && $stable(sdata)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && fall && !take && seen_q == CNT_W'(FRAME_W - 1)) |=> !sdata_oe);

  p_no_spurious_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_oe && !take) |=> !sdata_oe);

  p_ready_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_ready);

  p_quiet_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

endmodule

bind sdo_port sdo_port_chk #(.RES_W(RES_W), .PAD_W(PAD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .sdata     (sdata),
  .sdata_oe  (sdata_oe),
  .fall      (sclk_fall)
);

// File: tb/sim_sdo_port.sv
module sim_sdo_port;

  localparam int unsigned RW   = 6;
  localparam int unsigned PW   = 2;
  localparam int unsigned FW   = RW + PW;
  localparam int unsigned HALF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          res_valid = 1'b0;
  logic          res_ready;
  logic [RW-1:0] res_data = '0;
  logic          sdata;
  logic          sdata_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdo_port #(.RES_W(RW), .PAD_W(PW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic load(input logic [RW-1:0] v);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = v;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic rise_half();
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic fall_half();
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  function automatic logic exp_bit(input logic [RW-1:0] v, input int i);
    if (i < PW) return 1'b0;
    return v[RW-1-(i-PW)];
  endfunction

  initial begin
    // R1: reset state
    wait_clk(3);
    chk("R1 oe in reset", sdata_oe, 1'b0);
    chk("R1 sdata in reset", sdata, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", sdata_oe, 1'b0);
    chk("R1 sdata after reset", sdata, 1'b0);
    chk("R8 ready after reset", res_ready, 1'b1);

    // R6: edges before any load
    for (int e = 0; e < 3; e++) begin
      rise_half();
      fall_half();
      chk("R6 no load oe", sdata_oe, 1'b0);
      chk("R9 released low", sdata, 1'b0);
    end

    // R2/R3/R4/R5: full sweep of every result value
    for (int v = 0; v < (1 << RW); v++) begin
      load(RW'(v));
      chk("R2 oe after load", sdata_oe, 1'b1);
      chk("R8 ready held", res_ready, 1'b1);
      for (int i = 0; i < FW; i++) begin
        chk("R3 frame bit", sdata, exp_bit(RW'(v), i));
        rise_half();
        chk("R4 rising no change", sdata, exp_bit(RW'(v), i));
        chk("R4 oe kept", sdata_oe, 1'b1);
        fall_half();
      end
      chk("R5 released", sdata_oe, 1'b0);
      chk("R9 low after release", sdata, 1'b0);
    end

    // R5: edges after release keep the line released
    rise_half();
    fall_half();
    chk("R5 stays released", sdata_oe, 1'b0);

    // R7: reload mid-frame restarts at bit 0
    load(6'h3F);
    for (int i = 0; i < 5; i++) begin
      rise_half();
      fall_half();
    end
    chk("R7 mid-frame bit", sdata, exp_bit(6'h3F, 5));
    load(6'h2A);
    for (int i = 0; i < FW; i++) begin
      chk("R7 restarted bit", sdata, exp_bit(6'h2A, i));
      chk("R7 oe", sdata_oe, 1'b1);
      rise_half();
      fall_half();
    end
    chk("R7 release after full frame", sdata_oe, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule